// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the programmable feedback divider that sits behind a dual-modulus prescaler in a frequency synthesizer. Its clock stands for the oscillator-rate signal. A small counter inside the block models the prescaler: it divides by P or by P+1, as selected by the modulus-control output. Two counters then count prescaler cycles. The swallow counter holds the modulus at P+1 for the first A prescaler cycles of each output period. The main counter ends the period after B prescaler cycles. The divider therefore gives one output pulse every P*B + A input clocks.

Software writes a new swallow value and main value together, with a single load strobe. A legal pair waits in a pending register and takes effect only at the next period boundary, so no output period ever mixes two settings. A pair with a main value below the minimum, or with a swallow value larger than the main value, is refused. The refusal raises an error pulse and leaves the current setting in force.

Top module: `swallow_div`

## Requirements
- R1: After reset, divOut, cfgErr and modCtl are low. The reset setting is A=0 and B=3, so the first divOut pulse appears 24 input clocks after reset is released.
- R2: With a setting (A, B) in force, successive divOut pulses are exactly 8*B + A input clocks apart. P is 8.
- R3: Each divOut pulse is exactly one input clock wide.
- R4: In each output period, modCtl is high (divide-by-9) for the first A prescaler cycles, which is 9*A input clocks. It is low (divide-by-8) for the remaining B-A prescaler cycles.
- R5: A load whose cfgB (7 bits) is below 3 is refused. cfgErr goes high for one clock, in the cycle after the load, and the output period is unchanged.
- R6: A load whose cfgA (3 bits) is greater than cfgB is refused in the same way: a one-clock cfgErr pulse and an unchanged period.
- R7: A legal load made during an output period does not change that period. The new setting governs every period that starts after the next pulse.
- R8: The extremes are honoured. A = B gives a period of 9*B. B = 127 with A = 7 gives a period of 1023.
- R9: A legal load leaves cfgErr low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock at the oscillator rate |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | One-cycle strobe that captures cfgA and cfgB |
| cfgA | input | 3 | Swallow count A |
| cfgB | input | 7 | Main count B |
| modCtl | output | 1 | Modulus select: 1 selects P+1, 0 selects P |
| divOut | output | 1 | One-clock pulse at the end of each output period |
| cfgErr | output | 1 | One-clock pulse after a refused load |

## Verification
The bench targets the points where the modulus changes. A design that swallowed one cycle too many or too few would show periods off by one clock, and a modCtl high time that is not 9*A. The setting A equal to B is covered, and so is the largest main count with the largest swallow count.

A load is made in the middle of a period to catch a design that applies settings at once; such a design would shorten or stretch that period. Refused settings (B below 3, A above B) are checked for the error pulse and for an unchanged period, which would catch a design that takes an illegal setting or drops the one in force.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
  // Strobes from control to datapath, valid in the cycle of a prescaler tick
  typedef struct packed {
    logic nextMod;  // modulus of the prescaler cycle that follows this tick
    logic lastCyc;  // the current prescaler cycle closes the output period
  } divStrobeT;
endpackage

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl
  import swallow_div_pkg::*;
#(
  parameter int A_W   = 3,
  parameter int B_W   = 7,
  parameter int B_MIN = 3,
  parameter int RST_A = 0,
  parameter int RST_B = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgLoad,
  input  logic [A_W-1:0] cfgA,
  input  logic [B_W-1:0] cfgB,
  input  logic           tick,
  output divStrobeT      strobes,
  output logic           modCtl,
  output logic           cfgErr
);
  logic [A_W-1:0] actA, pendA, swCnt, nextA;
  logic [B_W-1:0] actB, pendB, mainCnt, nextB;
  logic           pendVld, cfgOk, lastCyc, periodEnd;

  assign cfgOk     = (cfgB >= B_W'(B_MIN)) && (B_W'(cfgA) <= cfgB);
  assign lastCyc   = (mainCnt == B_W'(1));
  assign periodEnd = tick && lastCyc;
  assign nextA     = pendVld ? pendA : actA;
  assign nextB     = pendVld ? pendB : actB;
  assign modCtl    = (swCnt != '0);

  always_comb begin
    strobes.lastCyc = lastCyc;
    strobes.nextMod = lastCyc ? (nextA != '0) : (swCnt > A_W'(1));
  end

  // Pending setting, captured from a legal load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendVld <= 1'b0;
      pendA   <= '0;
      pendB   <= '0;
      cfgErr  <= 1'b0;
    end else begin
      cfgErr <= cfgLoad && !cfgOk;
      if (cfgLoad && cfgOk) begin
        pendVld <= 1'b1;
        pendA   <= cfgA;
        pendB   <= cfgB;
      end else if (periodEnd) begin
        pendVld <= 1'b0;
      end
    end
  end

  // Active setting, swallow and main counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actA    <= A_W'(RST_A);
      actB    <= B_W'(RST_B);
      swCnt   <= A_W'(RST_A);
      mainCnt <= B_W'(RST_B);
    end else if (periodEnd) begin
      actA    <= nextA;
      actB    <= nextB;
      swCnt   <= nextA;
      mainCnt <= nextB;
    end else if (tick) begin
      mainCnt <= mainCnt - B_W'(1);
      if (swCnt != '0) swCnt <= swCnt - A_W'(1);
    end
  end

  AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (actB >= B_W'(B_MIN)) && (B_W'(actA) <= actB)); // R6
  AST_ERR_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $past(cfgLoad)); // R5
  AST_APPLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actB) |-> $past(periodEnd)); // R7
  AST_MOD_RISE_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modCtl) |-> $past(periodEnd)); // R4
endmodule

// File: rtl/swallow_div_dp.sv
module swallow_div_dp
  import swallow_div_pkg::*;
#(
  parameter int PRESC   = 8,
  parameter bit RST_MOD = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  divStrobeT strobes,
  output logic      tick,
  output logic      divOut
);
  localparam int PC_W = $clog2(PRESC + 1);
  localparam logic [PC_W-1:0] LOAD_HI = PC_W'(PRESC);
  localparam logic [PC_W-1:0] LOAD_LO = PC_W'(PRESC - 1);

  logic [PC_W-1:0] presCnt;

  assign tick = (presCnt == '0);

  // Digital model of the dual-modulus prescaler
  always_ff @(posedge clk) begin
    if (!rstN) begin
      presCnt <= RST_MOD ? LOAD_HI : LOAD_LO;
      divOut  <= 1'b0;
    end else begin
      divOut <= tick && strobes.lastCyc;
      if (tick) presCnt <= strobes.nextMod ? LOAD_HI : LOAD_LO;
      else      presCnt <= presCnt - PC_W'(1);
    end
  end

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    presCnt <= LOAD_HI); // R4
  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    divOut |-> $past(tick)); // R2
  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    divOut |=> !divOut); // R3
endmodule

// File: rtl/swallow_div.sv
module swallow_div
  import swallow_div_pkg::*;
#(
  parameter int PRESC = 8,
  parameter int A_W   = 3,
  parameter int B_W   = 7,
  parameter int B_MIN = 3,
  parameter int RST_A = 0,
  parameter int RST_B = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgLoad,
  input  logic [A_W-1:0] cfgA,
  input  logic [B_W-1:0] cfgB,
  output logic           modCtl,
  output logic           divOut,
  output logic           cfgErr
);
  localparam bit RST_MOD = (RST_A != 0);

  divStrobeT strobes;
  logic      tick;

  swallow_div_ctrl #(
    .A_W(A_W), .B_W(B_W), .B_MIN(B_MIN), .RST_A(RST_A), .RST_B(RST_B)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgA(cfgA), .cfgB(cfgB),
    .tick(tick), .strobes(strobes), .modCtl(modCtl), .cfgErr(cfgErr)
  );

  swallow_div_dp #(
    .PRESC(PRESC), .RST_MOD(RST_MOD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tick(tick), .divOut(divOut)
  );
endmodule

// File: tb/swallow_div_test.sv
`timescale 1ns/1ps
module swallow_div_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgLoad = 1'b0;
  logic [2:0] cfgA = '0;
  logic [6:0] cfgB = '0;
  logic       modCtl, divOut, cfgErr;
  int         nChecks = 0;
  int         nFails  = 0;
  bit         done    = 1'b0;

  always #5 clk = ~clk;

  swallow_div uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgA(cfgA), .cfgB(cfgB),
    .modCtl(modCtl), .divOut(divOut), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  task automatic waitPulse(input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!divOut && n < 2000);
    check({req, " pulse seen"}, divOut, 1);
  endtask

  // Count clocks up to the next pulse and the modCtl-high clocks in between
  task automatic measure(output int len, output int hi);
    len = 0;
    hi  = 0;
    do begin
      @(negedge clk);
      len++;
      if (modCtl) hi++;
      if (len == 1) check("R3 pulse width", divOut, 0);
    end while (!divOut && len < 2000);
  endtask

  task automatic loadCfg(input int a, input int b, input bit expErr, input string req);
    cfgA = 3'(a);
    cfgB = 7'(b);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    check({req, " cfgErr after load"}, cfgErr, int'(expErr));
    @(negedge clk);
    check({req, " cfgErr one clock"}, cfgErr, 0);
  endtask

  task automatic checkPeriod(input int a, input int b, input string req);
    int len, hi;
    measure(len, hi);
    check({req, " period"}, len, 8*b + a);
    check({"R4 modCtl high clocks ", req}, hi, 9*a);
  endtask

  task automatic testReset();
    int n = 0;
    check("R1 divOut at reset", divOut, 0);
    check("R1 cfgErr at reset", cfgErr, 0);
    check("R1 modCtl at reset", modCtl, 0);
    rstN = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!divOut && n < 100);
    check("R1 first pulse delay", n, 24);
    checkPeriod(0, 3, "R1 R2 default");
  endtask

  task automatic testSetting(input int a, input int b, input string req);
    loadCfg(a, b, 1'b0, "R9");
    waitPulse(req);
    checkPeriod(a, b, req);
    checkPeriod(a, b, req);
  endtask

  task automatic testRefused(input int a, input int b, input int oa, input int ob,
                             input string req);
    loadCfg(a, b, 1'b1, req);
    waitPulse(req);
    checkPeriod(oa, ob, {req, " held"});
  endtask

  task automatic testDeferred();
    int len, hi;
    waitPulse("R7");
    loadCfg(3, 9, 1'b0, "R7");
    measure(len, hi);
    check("R7 current period unchanged", len + 2, 8*20 + 0);
    checkPeriod(3, 9, "R7 next period");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testSetting(5, 10, "R2");
    testSetting(0, 20, "R2 A0");
    testSetting(7, 7, "R8 A=B");
    testSetting(7, 127, "R8 max");
    testSetting(1, 3, "R2 min B");
    testRefused(0, 2, 1, 3, "R5 B2");
    testRefused(0, 0, 1, 3, "R5 B0");
    testRefused(6, 5, 1, 3, "R6 A>B");
    testSetting(0, 20, "R2 reset to 20");
    testDeferred();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule